// File: doc/BRIEF.md
# Serial DAC Write Port Receiver

This block is the device-side receiver for a three-wire serial write port that loads a voltage DAC. A host drops an active-low frame-select line, presents serial data on a data line, and toggles a serial clock. The receiver samples one bit on each falling clock edge, most significant bit first, into a 16-bit frame. The two leading bits choose an output mode and the next RES bits carry a left-justified straight-binary DAC code. RES is 8, 10 or 12. Any bits below the code are don't-care.

The frame executes on exactly its sixteenth falling clock edge. At that point the code register and the mode register are loaded together, and a one-cycle update strobe is raised. If frame-select returns high before the sixteenth edge, the frame is discarded and nothing changes. After a frame executes, further clock edges are ignored until frame-select goes high again. The next frame starts only on a fresh falling edge of frame-select.

The three serial lines are asynchronous to the system clock. They pass through a synchronizer and an edge detector, and all state runs on the system clock. The ideal analog output is code / 2^RES of the supply. Only the registered code and the decoded mode indications leave this block.

Top module: `dac_serial_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, the DAC code is zero, the normal-mode indication is the only one set, and the update strobe is low.
- R2: Bits are taken on falling serial clock edges only, most significant bit first, while a frame is open. The code and mode change on the sixteenth falling edge and not before.
- R3: The mode field is frame bits 15:14. 00 sets the normal indication, 01 sets the 1k-to-ground indication, 10 sets the 100k-to-ground indication, and 11 sets the three-state indication. Exactly one indication is high at all times.
- R4: The DAC code is frame bits 13 down to 14-RES (bits 13:2 with RES=12). Frame bits below that field have no effect on any output.
- R5: If frame-select rises before the sixteenth falling edge, the frame is discarded. Neither the code nor the mode changes, and no strobe is issued.
- R6: After a frame executes, falling clock edges while frame-select stays low are ignored. A new frame begins only after frame-select has gone high and then fallen again.
- R7: The update strobe is high for exactly one cycle for each executed frame, and never otherwise. The code and mode registers change only in the cycle the strobe is high.
- R8: A frame selecting a power-down mode still loads its DAC code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsel_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, data taken on falling edge, asynchronous |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | RES | Registered straight-binary DAC code |
| out_normal | output | 1 | Normal operation selected |
| out_pd_1k | output | 1 | Power-down with 1k to ground selected |
| out_pd_100k | output | 1 | Power-down with 100k to ground selected |
| out_hiz | output | 1 | Power-down with three-state output selected |
| update_stb | output | 1 | One-cycle pulse when a frame executes |

## Verification
The assertions assume that every level of the serial clock and frame-select lasts at least two system clocks, so each edge is seen after synchronization. They also assume that a frame-select edge and a serial clock fall never land in the same sampled cycle, which keeps the abort and start decisions unambiguous. The stimulus holds each serial clock phase for four system clocks. It leaves four clocks between a frame-select fall and the first clock rise, and keeps frame-select high for six clocks between frames. Random words, random truncated lengths and random over-length tails are all driven with that spacing.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int FRAME_BITS = 16;
    localparam int MODE_MSB   = 15;
    localparam int DATA_MSB   = 13;

    typedef enum logic [1:0] {
        PD_NONE = 2'b00,
        PD_1K   = 2'b01,
        PD_100K = 2'b10,
        PD_HIZ  = 2'b11
    } pd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DONE
    } rx_state_e;

    typedef struct packed {
        logic fsel_fall;
        logic fsel_rise;
        logic clk_fall;
        logic data;
    } line_ev_t;

    typedef struct packed {
        logic normal;
        logic pd_1k;
        logic pd_100k;
        logic hiz;
    } mode_ind_t;

    function automatic mode_ind_t decode_mode(input pd_mode_e m);
        mode_ind_t r;
        r = '0;
        case (m)
            PD_NONE: r.normal  = 1'b1;
            PD_1K:   r.pd_1k   = 1'b1;
            PD_100K: r.pd_100k = 1'b1;
            default: r.hiz     = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dacif_edge.sv
module dacif_edge
    import dacif_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fsel_s,
    input  logic     sclk_s,
    input  logic     sdin_s,
    output line_ev_t ev
);
    logic fsel_d;
    logic sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel_d <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            fsel_d <= fsel_s;
            sclk_d <= sclk_s;
        end
    end

    always_comb begin
        ev.fsel_fall = fsel_d & ~fsel_s;
        ev.fsel_rise = ~fsel_d & fsel_s;
        ev.clk_fall  = sclk_d & ~sclk_s;
        ev.data      = sdin_s;
    end
endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter
    import dacif_pkg::*;
#(
    parameter int RES = 12,
    localparam int KEEP  = 2 + RES,
    localparam int CNT_W = $clog2(FRAME_BITS)
) (
    input  logic            clk,
    input  logic            rst,
    input  line_ev_t        ev,
    output logic            frame_ok,
    output logic [KEEP-1:0] frame_top
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    rx_state_e               state;
    logic [CNT_W-1:0]        cnt;
    logic [FRAME_BITS-1:0]   sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sreg     <= '0;
            frame_ok <= 1'b0;
        end else begin
            frame_ok <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ev.fsel_fall) begin
                        state <= ST_SHIFT;
                        cnt   <= '0;
                        sreg  <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (ev.fsel_rise) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                        sreg  <= '0;
                    end else if (ev.clk_fall) begin
                        sreg <= {sreg[FRAME_BITS-2:0], ev.data};
                        if (cnt == LAST) begin
                            state    <= ST_DONE;
                            cnt      <= '0;
                            frame_ok <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    if (ev.fsel_rise) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign frame_top = sreg[MODE_MSB -: KEEP];

    // R5: a frame-select rise mid-frame discards the frame
    p_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && ev.fsel_rise) |=> (state == ST_IDLE && !frame_ok));

    // R6: once executed, no further execution until frame-select returns high
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> !frame_ok);

    // R6: an idle receiver opens a frame only on a frame-select fall
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !ev.fsel_fall) |=> (state == ST_IDLE));

    // R2: execution follows a clock fall taken while shifting
    p_exec_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_ok) |-> ($past(state) == ST_SHIFT && $past(ev.clk_fall)));
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int RES = 12,
    localparam int KEEP = 2 + RES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [KEEP-1:0] frame_top,
    output logic [RES-1:0]  code,
    output mode_ind_t       ind,
    output logic            stb
);
    pd_mode_e mode_q;

    initial begin
        a_res_legal_r4: assert (RES == 8 || RES == 10 || RES == 12);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code   <= '0;
            mode_q <= PD_NONE;
            stb    <= 1'b0;
        end else begin
            stb <= load;
            if (load) begin
                mode_q <= pd_mode_e'(frame_top[KEEP-1 -: 2]);
                code   <= frame_top[RES-1:0];
            end
        end
    end

    assign ind = decode_mode(mode_q);

    // R7: registers move only with a load
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(code) && $stable(mode_q)));

    // R7: strobe is a single cycle
    p_stb_single_r7: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);

    // R3: exactly one mode indication
    p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(ind) == 1);
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
    import dacif_pkg::*;
#(
    parameter int RES         = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fsel_n,
    input  logic           sclk,
    input  logic           sdin,
    output logic [RES-1:0] dac_code,
    output logic           out_normal,
    output logic           out_pd_1k,
    output logic           out_pd_100k,
    output logic           out_hiz,
    output logic           update_stb
);
    localparam int KEEP = 2 + RES;

    logic [2:0]      lines_s;
    line_ev_t        ev;
    logic            frame_ok;
    logic [KEEP-1:0] frame_top;
    mode_ind_t       ind;

    dacif_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({fsel_n, sclk, sdin}),
        .dout (lines_s)
    );

    dacif_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .fsel_s (lines_s[2]),
        .sclk_s (lines_s[1]),
        .sdin_s (lines_s[0]),
        .ev     (ev)
    );

    dacif_shifter #(.RES(RES)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .frame_ok  (frame_ok),
        .frame_top (frame_top)
    );

    dacif_regs #(.RES(RES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_ok),
        .frame_top (frame_top),
        .code      (dac_code),
        .ind       (ind),
        .stb       (update_stb)
    );

    assign out_normal  = ind.normal;
    assign out_pd_1k   = ind.pd_1k;
    assign out_pd_100k = ind.pd_100k;
    assign out_hiz     = ind.hiz;

    // R1: state just after reset
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_code == '0 && out_normal && !update_stb));

    // R7: any code change is accompanied by the strobe
    p_change_stb_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_code) |-> update_stb);
endmodule

// File: tb/sim_dac_serial_rx.sv
module sim_dac_serial_rx;
    localparam int RES = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdin = 1'b0;
    logic [RES-1:0] dac_code;
    logic out_normal, out_pd_1k, out_pd_100k, out_hiz, update_stb;

    int compared = 0;
    int mismatched = 0;
    int stb_cnt = 0;
    int stb_long = 0;
    logic stb_prev = 1'b0;
    logic finished = 1'b0;

    logic [RES-1:0] exp_code;
    logic [1:0]     exp_mode;

    always #4 clk = ~clk;

    dac_serial_rx #(.RES(RES), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .fsel_n(fsel_n), .sclk(sclk), .sdin(sdin),
        .dac_code(dac_code), .out_normal(out_normal), .out_pd_1k(out_pd_1k),
        .out_pd_100k(out_pd_100k), .out_hiz(out_hiz), .update_stb(update_stb)
    );

    always @(negedge clk) begin
        if (rst) begin
            stb_prev = 1'b0;
        end else begin
            if (update_stb) stb_cnt++;
            if (update_stb && stb_prev) stb_long++;
            stb_prev = update_stb;
        end
    end

    function automatic logic [3:0] ind_of(input logic [1:0] m);
        case (m)
            2'b00:   return 4'b1000;
            2'b01:   return 4'b0100;
            2'b10:   return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [RES-1:0] code_of(input logic [15:0] w);
        return w[13 -: RES];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, 32'(dac_code), 32'(exp_code));
        chk(req, {28'd0, out_normal, out_pd_1k, out_pd_100k, out_hiz}, {28'd0, ind_of(exp_mode)});
    endtask

    task automatic frame(input logic [15:0] w, input int nfall, input int extra);
        int s0;
        s0 = stb_cnt;
        fsel_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nfall; i++) begin
            sclk = 1'b1;
            sdin = w[15-i];
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
            if (i == 14) begin
                wait_clk(2);
                chk_state("R2 no update before 16th edge");
            end
        end
        wait_clk(2);
        if (nfall >= 16) begin
            exp_code = code_of(w);
            exp_mode = w[15:14];
            chk_state("R2 R3 R4 R8 update on 16th edge");
            chk("R7 one strobe per frame", 32'(stb_cnt - s0), 32'd1);
        end else begin
            chk_state("R5 short frame no change");
            chk("R5 no strobe on short frame", 32'(stb_cnt - s0), 32'd0);
        end
        if (extra > 0) begin
            s0 = stb_cnt;
            for (int j = 0; j < extra; j++) begin
                sclk = 1'b1;
                sdin = 1'($urandom);
                wait_clk(4);
                sclk = 1'b0;
                wait_clk(4);
            end
            wait_clk(2);
            chk_state("R6 extra edges ignored");
            chk("R6 no strobe on extra edges", 32'(stb_cnt - s0), 32'd0);
        end
        s0 = stb_cnt;
        fsel_n = 1'b1;
        wait_clk(6);
        chk_state("R5 R6 state after frame-select rise");
        chk("R7 no strobe on rise", 32'(stb_cnt - s0), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        exp_code = '0;
        exp_mode = 2'b00;
        wait_clk(5);
        chk_state("R1 reset state");
        chk("R1 strobe low in reset", 32'(update_stb), 32'd0);
        rst = 1'b0;
        wait_clk(1);
        chk_state("R1 after reset");
        chk("R1 strobe low after reset", 32'(update_stb), 32'd0);

        frame({2'b00, 12'hABC, 2'b11}, 16, 0);      // R4 low bits set
        frame({2'b00, 12'hABC, 2'b00}, 16, 0);      // R4 low bits clear, same code
        frame({2'b01, 12'hFFF, 2'b10}, 16, 0);      // R3 1k, R8
        frame({2'b10, 12'h000, 2'b01}, 16, 0);      // R3 100k
        frame({2'b11, 12'h123, 2'b11}, 16, 0);      // R3 three-state
        frame({2'b00, 12'h555, 2'b00}, 15, 0);      // R5 abort at 15
        frame({2'b01, 12'h321, 2'b00}, 1, 0);       // R5 abort at 1
        frame({2'b00, 12'h800, 2'b00}, 0, 0);       // R5 empty frame
        frame({2'b01, 12'h7E1, 2'b00}, 16, 3);      // R6 over-length
        frame({2'b10, 12'h0F0, 2'b00}, 16, 16);     // R6 full second frame ignored
        frame({2'b00, 12'h001, 2'b00}, 16, 0);      // R2 MSB-first LSB code

        for (int k = 0; k < 40; k++) begin
            logic [15:0] w;
            int n;
            int x;
            w = 16'($urandom);
            n = ($urandom % 10 < 7) ? 16 : int'($urandom % 15) + 1;
            x = (n == 16) ? int'($urandom % 4) : 0;
            frame(w, n, x);
        end

        chk("R7 strobe width", 32'(stb_long), 32'd0);

        rst = 1'b1;
        wait_clk(2);
        exp_code = '0;
        exp_mode = 2'b00;
        chk_state("R1 reset mid-run");
        rst = 1'b0;
        wait_clk(2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule